// File: doc/BRIEF.md
# Configurable Macrocell Register Control

This block models the storage element of a single programmable-logic macrocell and the steering logic around it. A static configuration word picks the register's clock from three global clocks or from a product term, optionally uses a product term as a clock enable, and builds an asynchronous clear from a global clear line and a product term. A second product term can act either as an asynchronous set or as an output enable. The storage element can behave as a D flip-flop, a toggle flip-flop or a transparent latch. A polarity bit inverts the incoming logic term and also fixes the register's power-on value.

The model is cycle-based. Every input is sampled on a fast system clock `clk`. A rising edge of the selected macrocell clock is seen when that clock is sampled high after having been sampled low. Clear and set take effect at the next system clock edge. `rst_n` is the power-on reset. The block drives a feedback output and an output-enable output. Generating the product terms and the pad electrical options belong to neighbouring logic.

Top module: `mc_regctl`

## Requirements
- R1: While `rst_n` is low, the register takes the power-on value at every `clk` edge. The power-on value is the inverse of the polarity bit (cfg bit 11). The clock-edge detector starts as if the selected clock had last been high, so a clock that is already high at release does not count as an edge.
- R2: Clock-select field cfg[1:0]: 0 picks `gclk[0]`, 1 picks `gclk[1]` and 2 picks `gclk[2]`. Code 3 is unused and gives a clock that stays low. In D mode (cfg[10:9] = 0 or 3) the register loads the data term at the `clk` edge where the selected clock is first sampled high.
- R3: With product term 4 taken out of the sum (cfg bit 2 = 0) and routed to the clock (cfg bit 3 = 1), `pt4` is the register clock, the global clocks have no effect and the clock enable is 1.
- R4: With cfg bit 2 = 0 and cfg bit 3 = 0, `pt4` is a clock enable: the register changes only when `pt4` is 1, and the clock follows the global select. With cfg bit 2 = 1, `pt4` has no effect.
- R5: The clear is active when (`gclr` XOR cfg bit 5) AND cfg bit 4 is true, or when `pt3` AND cfg bit 6 is true. With both enables at 0 the register is never cleared.
- R6: When cfg bit 7 = 0 and cfg bit 8 = 0, `pt5` is an asynchronous set that forces the register to 1. In every other setting `pt5` never sets the register.
- R7: Clear forces the register to 0 and wins over set and over any clock event. Clear and set ignore the polarity bit.
- R8: The data term is `xor_in` XOR the polarity bit (cfg bit 11).
- R9: In toggle mode (cfg[10:9] = 1) a clock edge inverts the register when the data term is 1 and leaves it unchanged when the data term is 0.
- R10: In latch mode (cfg[10:9] = 2) the register takes the data term at every `clk` edge while the selected clock is high and the enable is 1. It holds its value while the clock is low.
- R11: Feedback select cfg bit 12 = 1 puts the register output on `fb_out`; 0 puts the data term on `fb_out`.
- R12: OE select cfg[15:13]: 0 to 3 pick `goe[0..3]`, 4 gives 0, 5 gives 1 when `pt5` is in the sum or acts as set and gives `pt5` otherwise, and 6 or 7 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Power-on reset, active low |
| cfg_word | input | 16 | Static configuration word |
| gclk | input | 3 | Global clock lines |
| gclr | input | 1 | Global clear line, before polarity selection |
| goe | input | 4 | Global output-enable lines |
| pt3 | input | 1 | Product term used for clear |
| pt4 | input | 1 | Product term used for clock or clock enable |
| pt5 | input | 1 | Product term used for set or output enable |
| xor_in | input | 1 | Combinational logic term before polarity |
| reg_q | output | 1 | Register output |
| fb_out | output | 1 | Feedback to the routing array |
| oe_out | output | 1 | Output enable for the pad |

## Verification
Clear, set and a clock event can all be true in the same system cycle. So can a toggle edge and a clear. The bench sweeps every setting of the lower thirteen configuration bits and drives pseudo-random values on all clock, clear, set and data inputs, so these overlaps come up often. In every step it predicts the register from the stated priority: clear, then set, then the selected storage mode. The same steps cover an edge arriving while `pt4` is low in clock-enable mode and a latch opening while a set is held, and each is judged against the next-cycle value of `reg_q`.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

   typedef enum logic [1:0] {
      STORE_D      = 2'd0,
      STORE_TOGGLE = 2'd1,
      STORE_LATCH  = 2'd2,
      STORE_RSVD   = 2'd3
   } store_mode_e;

   // Flag offsets relative to the end of the clock-select field
   localparam int unsigned OFS_PT4_SUM  = 0;
   localparam int unsigned OFS_PT4_CLK  = 1;
   localparam int unsigned OFS_GCLR_EN  = 2;
   localparam int unsigned OFS_GCLR_INV = 3;
   localparam int unsigned OFS_PT3_EN   = 4;
   localparam int unsigned OFS_PT5_SUM  = 5;
   localparam int unsigned OFS_PT5_OE   = 6;
   localparam int unsigned OFS_MODE     = 7;
   localparam int unsigned OFS_POL      = 9;
   localparam int unsigned OFS_FB_REG   = 10;
   localparam int unsigned OFS_OE_SEL   = 11;

   typedef struct packed {
      logic        pt4_in_sum;
      logic        pt4_is_clk;
      logic        gclr_en;
      logic        gclr_inv;
      logic        pt3_rst_en;
      logic        pt5_in_sum;
      logic        pt5_is_oe;
      store_mode_e mode;
      logic        pol_inv;
      logic        fb_reg;
   } mc_flags_t;

endpackage

// File: rtl/mc_cfg_decode.sv
`timescale 1ns/1ps
module mc_cfg_decode
   import mc_pkg::*;
#(
   parameter int CSEL_W  = 2,
   parameter int OESEL_W = 3,
   localparam int BASE   = CSEL_W,
   localparam int CFG_W  = CSEL_W + OFS_OE_SEL + OESEL_W
) (
   input  logic [CFG_W-1:0]   cfg_word,
   output logic [CSEL_W-1:0]  clk_idx,
   output logic [OESEL_W-1:0] oe_idx,
   output mc_flags_t          flags
);

   always_comb begin
      clk_idx          = cfg_word[CSEL_W-1:0];
      oe_idx           = cfg_word[BASE+OFS_OE_SEL +: OESEL_W];
      flags.pt4_in_sum = cfg_word[BASE+OFS_PT4_SUM];
      flags.pt4_is_clk = cfg_word[BASE+OFS_PT4_CLK];
      flags.gclr_en    = cfg_word[BASE+OFS_GCLR_EN];
      flags.gclr_inv   = cfg_word[BASE+OFS_GCLR_INV];
      flags.pt3_rst_en = cfg_word[BASE+OFS_PT3_EN];
      flags.pt5_in_sum = cfg_word[BASE+OFS_PT5_SUM];
      flags.pt5_is_oe  = cfg_word[BASE+OFS_PT5_OE];
      flags.mode       = store_mode_e'(cfg_word[BASE+OFS_MODE +: 2]);
      flags.pol_inv    = cfg_word[BASE+OFS_POL];
      flags.fb_reg     = cfg_word[BASE+OFS_FB_REG];
   end

endmodule

// File: rtl/mc_clk_ctrl.sv
`timescale 1ns/1ps
module mc_clk_ctrl #(
   parameter int NUM_GCLK = 3,
   parameter int CSEL_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic [CSEL_W-1:0]   clk_idx,
   input  logic                pt4,
   input  logic                pt4_in_sum,
   input  logic                pt4_is_clk,
   output logic                clk_rise,
   output logic                clk_open
);

   logic [NUM_GCLK-1:0] hit;
   logic                gsel;
   logic                pt4_ctl;
   logic                mc_clk;
   logic                mc_ce;
   logic                clk_prev;

   // One-hot pick of the global clock; codes past NUM_GCLK select nothing
   for (genvar i = 0; i < NUM_GCLK; i++) begin : g_gclk
      assign hit[i] = gclk[i] & (clk_idx == CSEL_W'(i));
   end

   always_comb begin
      gsel    = |hit;
      pt4_ctl = ~pt4_in_sum;
      mc_clk  = (pt4_ctl & pt4_is_clk) ? pt4 : gsel;
      mc_ce   = (pt4_ctl & ~pt4_is_clk) ? pt4 : 1'b1;
   end

   // Edge detector starts "high" so a clock already high at release is no edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev <= 1'b1;
      else        clk_prev <= mc_clk;
   end

   assign clk_rise = mc_clk & ~clk_prev & mc_ce;
   assign clk_open = mc_clk & mc_ce;

endmodule

// File: rtl/mc_async_ctrl.sv
`timescale 1ns/1ps
module mc_async_ctrl (
   input  logic gclr,
   input  logic gclr_en,
   input  logic gclr_inv,
   input  logic pt3,
   input  logic pt3_rst_en,
   input  logic pt5,
   input  logic pt5_in_sum,
   input  logic pt5_is_oe,
   output logic clr,
   output logic set
);

   logic gclr_eff;

   always_comb begin
      gclr_eff = gclr ^ gclr_inv;
      clr      = (gclr_eff & gclr_en) | (pt3 & pt3_rst_en);
      set      = pt5 & ~pt5_in_sum & ~pt5_is_oe;
   end

endmodule

// File: rtl/mc_store.sv
`timescale 1ns/1ps
module mc_store
   import mc_pkg::*;
#(
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  store_mode_e mode,
   input  logic        pol_inv,
   input  logic        d_src,
   input  logic        clk_rise,
   input  logic        clk_open,
   input  logic        clr,
   input  logic        set,
   output logic        q
);

   logic q_clocked;
   logic q_next;

   // The toggle variant exists only when the library build keeps it
   if (HAS_TOGGLE) begin : g_toggle
      always_comb begin
         unique case (mode)
            STORE_TOGGLE: q_clocked = clk_rise ? (q ^ d_src) : q;
            STORE_LATCH:  q_clocked = clk_open ? d_src : q;
            default:      q_clocked = clk_rise ? d_src : q;
         endcase
      end
   end else begin : g_no_toggle
      always_comb begin
         unique case (mode)
            STORE_LATCH: q_clocked = clk_open ? d_src : q;
            default:     q_clocked = clk_rise ? d_src : q;
         endcase
      end
   end

   // Clear outranks set, set outranks the storage path
   always_comb begin
      if (clr)      q_next = 1'b0;
      else if (set) q_next = 1'b1;
      else          q_next = q_clocked;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= ~pol_inv;
      else        q <= q_next;
   end

endmodule

// File: rtl/mc_oe_mux.sv
`timescale 1ns/1ps
module mc_oe_mux #(
   parameter int NUM_GOE = 4,
   parameter int OESEL_W = 3
) (
   input  logic [NUM_GOE-1:0] goe,
   input  logic [OESEL_W-1:0] oe_idx,
   input  logic               pt5,
   input  logic               pt5_in_sum,
   input  logic               pt5_is_oe,
   output logic               oe
);

   localparam int SEL_HI = NUM_GOE + 1;

   logic [NUM_GOE-1:0] hit;
   logic               hi_pick;

   for (genvar i = 0; i < NUM_GOE; i++) begin : g_goe
      assign hit[i] = goe[i] & (oe_idx == OESEL_W'(i));
   end

   always_comb begin
      // Code NUM_GOE matches no line and yields 0
      hi_pick = (pt5_in_sum | ~pt5_is_oe) ? 1'b1 : pt5;
      oe      = (|hit) | ((oe_idx == OESEL_W'(SEL_HI)) & hi_pick);
   end

endmodule

// File: rtl/mc_regctl.sv
`timescale 1ns/1ps
module mc_regctl
   import mc_pkg::*;
#(
   parameter int  NUM_GCLK   = 3,
   parameter int  NUM_GOE    = 4,
   parameter bit  HAS_TOGGLE = 1'b1,
   localparam int CSEL_W     = $clog2(NUM_GCLK + 1),
   localparam int OESEL_W    = $clog2(NUM_GOE + 2),
   localparam int CFG_W      = CSEL_W + OFS_OE_SEL + OESEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CFG_W-1:0]    cfg_word,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                gclr,
   input  logic [NUM_GOE-1:0]  goe,
   input  logic                pt3,
   input  logic                pt4,
   input  logic                pt5,
   input  logic                xor_in,
   output logic                reg_q,
   output logic                fb_out,
   output logic                oe_out
);

   if (NUM_GCLK < 1 || NUM_GCLK > 15) begin : g_bad_gclk
      $error("mc_regctl: NUM_GCLK must be 1..15");
   end
   if (NUM_GOE < 1 || NUM_GOE > 30) begin : g_bad_goe
      $error("mc_regctl: NUM_GOE must be 1..30");
   end

   logic [CSEL_W-1:0]  clk_idx;
   logic [OESEL_W-1:0] oe_idx;
   mc_flags_t          flags;
   logic               clk_rise;
   logic               clk_open;
   logic               clr;
   logic               set;
   logic               d_src;

   mc_cfg_decode #(.CSEL_W(CSEL_W), .OESEL_W(OESEL_W)) u_dec (
      .cfg_word (cfg_word),
      .clk_idx  (clk_idx),
      .oe_idx   (oe_idx),
      .flags    (flags)
   );

   mc_clk_ctrl #(.NUM_GCLK(NUM_GCLK), .CSEL_W(CSEL_W)) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .gclk       (gclk),
      .clk_idx    (clk_idx),
      .pt4        (pt4),
      .pt4_in_sum (flags.pt4_in_sum),
      .pt4_is_clk (flags.pt4_is_clk),
      .clk_rise   (clk_rise),
      .clk_open   (clk_open)
   );

   mc_async_ctrl u_async (
      .gclr       (gclr),
      .gclr_en    (flags.gclr_en),
      .gclr_inv   (flags.gclr_inv),
      .pt3        (pt3),
      .pt3_rst_en (flags.pt3_rst_en),
      .pt5        (pt5),
      .pt5_in_sum (flags.pt5_in_sum),
      .pt5_is_oe  (flags.pt5_is_oe),
      .clr        (clr),
      .set        (set)
   );

   assign d_src = xor_in ^ flags.pol_inv;

   mc_store #(.HAS_TOGGLE(HAS_TOGGLE)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (flags.mode),
      .pol_inv  (flags.pol_inv),
      .d_src    (d_src),
      .clk_rise (clk_rise),
      .clk_open (clk_open),
      .clr      (clr),
      .set      (set),
      .q        (reg_q)
   );

   mc_oe_mux #(.NUM_GOE(NUM_GOE), .OESEL_W(OESEL_W)) u_oe (
      .goe        (goe),
      .oe_idx     (oe_idx),
      .pt5        (pt5),
      .pt5_in_sum (flags.pt5_in_sum),
      .pt5_is_oe  (flags.pt5_is_oe),
      .oe         (oe_out)
   );

   assign fb_out = flags.fb_reg ? reg_q : d_src;

endmodule

// File: rtl/mc_regctl_chk.sv
`timescale 1ns/1ps
module mc_regctl_chk
   import mc_pkg::*;
#(
   parameter int  NUM_GCLK   = 3,
   parameter int  NUM_GOE    = 4,
   parameter bit  HAS_TOGGLE = 1'b1,
   localparam int CSEL_W     = $clog2(NUM_GCLK + 1),
   localparam int OESEL_W    = $clog2(NUM_GOE + 2),
   localparam int CFG_W      = CSEL_W + OFS_OE_SEL + OESEL_W,
   localparam int B          = CSEL_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_word,
   input logic             gclr,
   input logic             pt3,
   input logic             pt5,
   input logic             xor_in,
   input logic             reg_q,
   input logic             fb_out,
   input logic             oe_out
);

   logic clr_now, set_now, pt4_clocks, pol, no_gclk;
   logic [1:0] mode_now;
   logic [OESEL_W-1:0] oe_sel;

   always_comb begin
      pol        = cfg_word[B+OFS_POL];
      clr_now    = ((gclr ^ cfg_word[B+OFS_GCLR_INV]) & cfg_word[B+OFS_GCLR_EN])
                 | (pt3 & cfg_word[B+OFS_PT3_EN]);
      set_now    = pt5 & ~cfg_word[B+OFS_PT5_SUM] & ~cfg_word[B+OFS_PT5_OE];
      pt4_clocks = ~cfg_word[B+OFS_PT4_SUM] & cfg_word[B+OFS_PT4_CLK];
      no_gclk    = cfg_word[CSEL_W-1:0] >= CSEL_W'(NUM_GCLK);
      mode_now   = cfg_word[B+OFS_MODE +: 2];
      oe_sel     = cfg_word[B+OFS_OE_SEL +: OESEL_W];
   end

   a_r1_poweron: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (reg_q == ~pol));

   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_now |=> !reg_q);

   a_r6_set_forces_one: assert property (@(posedge clk) disable iff (!rst_n)
      (set_now && !clr_now) |=> reg_q);

   a_r2_unused_clock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (no_gclk && !pt4_clocks && !clr_now && !set_now) |=> $stable(reg_q));

   a_r9_toggle_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_TOGGLE && mode_now == 2'd1 && (xor_in ^ pol) == 1'b0
       && !clr_now && !set_now) |=> $stable(reg_q));

   a_r11_fb_register: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_word[B+OFS_FB_REG] |-> (fb_out == reg_q));

   a_r8_fb_data_term: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_word[B+OFS_FB_REG] |-> (fb_out == (xor_in ^ pol)));

   a_r12_oe_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_sel == OESEL_W'(NUM_GOE)) |-> !oe_out);

   a_r12_oe_const_one: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_sel == OESEL_W'(NUM_GOE + 1) && !cfg_word[B+OFS_PT5_OE]) |-> oe_out);

endmodule

bind mc_regctl mc_regctl_chk #(
   .NUM_GCLK   (NUM_GCLK),
   .NUM_GOE    (NUM_GOE),
   .HAS_TOGGLE (HAS_TOGGLE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_word (cfg_word),
   .gclr     (gclr),
   .pt3      (pt3),
   .pt5      (pt5),
   .xor_in   (xor_in),
   .reg_q    (reg_q),
   .fb_out   (fb_out),
   .oe_out   (oe_out)
);

// File: tb/mc_regctl_bench.sv
`timescale 1ns/1ps
module mc_regctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_word = '0;
   logic [2:0]  gclk = '0;
   logic        gclr = 1'b0;
   logic [3:0]  goe = '0;
   logic        pt3 = 1'b0, pt4 = 1'b0, pt5 = 1'b0, xor_in = 1'b0;
   logic        reg_q, fb_out, oe_out;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   mc_regctl u_mc_regctl (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .gclk(gclk), .gclr(gclr),
      .goe(goe), .pt3(pt3), .pt4(pt4), .pt5(pt5), .xor_in(xor_in),
      .reg_q(reg_q), .fb_out(fb_out), .oe_out(oe_out)
   );

   // Bench reference state
   logic        bq, bprev;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input logic got, input logic exp, input string tag, input string what);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0b expected=%0b cfg=%h t=%0t", tag, what, got, exp, cfg_word, $time);
      end
   endtask

   task automatic drive_random();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gclk   = lfsr[2:0];
      gclr   = lfsr[3];
      pt3    = lfsr[4] & lfsr[9];
      pt4    = lfsr[5];
      pt5    = lfsr[6] & lfsr[11];
      xor_in = lfsr[7];
      goe    = lfsr[15:12];
   endtask

   function automatic logic exp_oe();
      logic [2:0] s;
      s = cfg_word[15:13];
      if (s < 3'd4)       return goe[s[1:0]];
      else if (s == 3'd5) return (cfg_word[7] | ~cfg_word[8]) ? 1'b1 : pt5;
      else                return 1'b0;                         // R12: 4, 6, 7
   endfunction

   initial begin
      #(190000 * 5);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic pol, d, selg, clkv, ce, clr, set, pt4ctl, rise, open;
      logic [1:0] mode;
      string tag;
      @(posedge clk); #1;
      for (int idx = 0; idx < 8192; idx++) begin
         cfg_word[12:0]  = idx[12:0];
         cfg_word[15:13] = 3'((idx * 3 + (idx >> 5)) % 8);
         pol  = cfg_word[11];
         mode = cfg_word[10:9];
         // Power-on step (R1)
         rst_n = 1'b0;
         drive_random();
         #1;
         chk(oe_out, exp_oe(), "R12", "oe_out in reset");
         bq = ~pol; bprev = 1'b1;
         @(posedge clk); #1;
         chk(reg_q, bq, "R1", "power-on value");
         rst_n = 1'b1;
         for (int s = 0; s < 9; s++) begin
            drive_random();
            #1;
            d = xor_in ^ pol;                                   // R8
            chk(fb_out, cfg_word[12] ? bq : d, "R11 R8", "fb_out");
            chk(oe_out, exp_oe(), "R12", "oe_out");
            // Predict next register value
            selg   = (cfg_word[1:0] < 2'd3) ? gclk[cfg_word[1:0]] : 1'b0;
            pt4ctl = ~cfg_word[2];
            clkv   = (pt4ctl & cfg_word[3]) ? pt4 : selg;
            ce     = (pt4ctl & ~cfg_word[3]) ? pt4 : 1'b1;
            clr    = ((gclr ^ cfg_word[5]) & cfg_word[4]) | (pt3 & cfg_word[6]);
            set    = pt5 & ~cfg_word[7] & ~cfg_word[8];
            rise   = clkv & ~bprev & ce;
            open   = clkv & ce;
            if (clr) begin
               bq = 1'b0; tag = "R5 R7";
            end else if (set) begin
               bq = 1'b1; tag = "R6";
            end else begin
               case (mode)
                  2'd1:    begin if (rise) bq = bq ^ d; tag = "R9"; end
                  2'd2:    begin if (open) bq = d;      tag = "R10"; end
                  default: begin if (rise) bq = d;      tag = "R2"; end
               endcase
               if (pt4ctl & cfg_word[3])       tag = {tag, " R3"};
               else                            tag = {tag, " R4"};
            end
            bprev = clkv;
            @(posedge clk); #1;
            chk(reg_q, bq, tag, "reg_q");
         end
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule